// File: doc/BRIEF.md
# Streaming 3x3 Laplacian Convolution Engine

This block filters one square frame of 32-bit pixels per run. Pixels arrive in raster order from a FIFO-style read port, at most one per cycle. The block keeps the two preceding image rows in line buffers and holds a 3x3 neighbourhood in window registers. Each time the neighbourhood lies fully inside the frame, it forms the weighted sum of the nine pixels: the centre is weighted +8 and each of the eight neighbours -1. The result goes out through a FIFO-style write port. For the default 20x20 frame a run gives 18x18 results, in raster order.

A block-level handshake controls it. The controller has four states. IDLE waits for `start`. SCAN reads the 400 pixels through one flattened counter, with separate column and row indices. DRAIN lets the arithmetic pipeline empty. DONE holds `done` until `cont` is seen. The transitions are: IDLE->SCAN on `start`; SCAN->DRAIN when the last pixel is read; DRAIN->DONE in the cycle the final result is written; DONE->IDLE on `cont`. While the input is empty or the output is full in SCAN, or the output is full in DRAIN, every pipeline register holds its value.

Top module: `conv_stream`

## Requirements
- R1: A synchronous active-high `rst` forces IDLE: `idle`=1 and `done`, `ready`, `in_rd` and `out_wr` are all 0 from the next clock edge on, including when reset cuts a run short.
- R2: `start` while in IDLE begins a run: `idle` is 0 from the next cycle on.
- R3: A run writes exactly 18x18=324 words. For row r and column c with both at least 2 (both counted from 0), the word is 8*p(r-1,c-1) minus the other eight pixels of rows r-2..r and columns c-2..c. Words come out in raster order.
- R4: `in_rd` is never high while `in_nempty` is low. An empty input freezes the pipeline, so `out_wr` stays low too.
- R5: While `out_nfull` is low, neither `in_rd` nor `out_wr` is high.
- R6: `ready` is high for exactly one cycle per run: the cycle in which the 400th pixel is read.
- R7: `done` rises in the cycle after the last result is written. It stays high, with `idle` also high, until `cont` is sampled high, and the block then returns to IDLE.
- R8: `start` in the DONE state is ignored. No pixel is read and `done` stays high until `cont` arrives.
- R9: With no stalls, the first result is written LAT+1 cycles after the cycle in which pixel (2,2) is read (3 cycles with the default LAT=2).
- R10: The sum wraps modulo 2^32 in two's complement. Overflowing inputs give the truncated low 32 bits.
- R11: Outside a run (`idle` high), `in_rd` and `out_wr` stay low whatever the FIFO flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled in IDLE) |
| cont | input | 1 | Acknowledge `done` and return to IDLE |
| done | output | 1 | Run finished, held until `cont` |
| idle | output | 1 | No run in progress (IDLE or DONE) |
| ready | output | 1 | Pulse in the cycle the last pixel is read |
| in_data | input | 32 | Pixel from the input FIFO |
| in_nempty | input | 1 | Input FIFO holds a word |
| in_rd | output | 1 | Pop strobe to the input FIFO |
| out_data | output | 32 | Filtered result |
| out_nfull | input | 1 | Output FIFO can take a word |
| out_wr | output | 1 | Push strobe to the output FIFO |

## Verification
Two events often fall in the same cycle: a pixel read and a result write. Both need `out_nfull`, so one output-full cycle must block both. The bench provokes this with periodic gaps on the input and backpressure on the output, alone and overlapping. It judges the result by comparing every written word, in order, with a model computed from the frame. It also checks that no strobe appears while its flag forbids it. A second coincidence is the last result write and the DRAIN->DONE transition. The bench checks that `done` appears exactly one cycle after that write.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DRAIN, ST_DONE} conv_state_t;

    localparam int KN = 9;      // window taps
    localparam int KCTR = 4;    // index of centre tap (row-major 3x3)

    function automatic int coef(input int k);
        return (k == KCTR) ? 8 : -1;
    endfunction
endpackage

// File: rtl/conv_window.sv
module conv_window
    import conv_pkg::*;
#(
    parameter int W  = 20,
    parameter int H  = 20,
    parameter int DW = 32,
    localparam int CW = $clog2(W),
    localparam int RW = $clog2(H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          rd,
    input  logic [DW-1:0] pix,
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] row,
    output logic [DW-1:0] win [KN],
    output logic          win_vld
);
    localparam int LINES = 2;

    logic [DW-1:0] lbuf [LINES][W];
    logic [DW-1:0] newc [3];

    // Line storage: line 0 is two rows back, line 1 one row back.
    for (genvar l = 0; l < LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (rd) begin
                if (l == LINES - 1) lbuf[l][col] <= pix;
                else                lbuf[l][col] <= lbuf[l+1][col];
            end
        end
    end

    always_comb begin
        newc[0] = lbuf[0][col];
        newc[1] = lbuf[1][col];
        newc[2] = pix;
    end

    // Window: win[r*3+c], r=2 newest row, c=2 newest column.
    for (genvar r = 0; r < 3; r++) begin : g_wrow
        always_ff @(posedge clk) begin
            if (rst) begin
                win[r*3+0] <= '0;
                win[r*3+1] <= '0;
                win[r*3+2] <= '0;
            end else if (adv && rd) begin
                win[r*3+0] <= win[r*3+1];
                win[r*3+1] <= win[r*3+2];
                win[r*3+2] <= newc[r];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      win_vld <= 1'b0;
        else if (adv) win_vld <= rd && (row >= RW'(2)) && (col >= CW'(2));
    end
endmodule

// File: rtl/conv_mac.sv
module conv_mac
    import conv_pkg::*;
#(
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [DW-1:0] win [KN],
    input  logic          vin,
    output logic [DW-1:0] od,
    output logic          ov,
    output logic          tail_only
);
    logic [DW-1:0] acc;
    logic [DW-1:0] pd [LAT];
    logic [LAT-1:0] pv;
    logic [LAT:0]  allv;

    always_comb begin
        acc = '0;
        for (int k = 0; k < KN; k++) begin
            acc = acc + DW'(coef(k)) * win[k];
        end
    end

    for (genvar i = 0; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                pv[i] <= 1'b0;
                pd[i] <= '0;
            end else if (adv) begin
                if (i == 0) begin
                    pv[i] <= vin;
                    pd[i] <= acc;
                end else begin
                    pv[i] <= pv[(i == 0) ? 0 : i-1];
                    pd[i] <= pd[(i == 0) ? 0 : i-1];
                end
            end
        end
    end

    always_comb begin
        allv      = {pv, vin};
        tail_only = ~|allv[LAT-1:0];
        od        = pd[LAT-1];
        ov        = pv[LAT-1];
    end
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
    import conv_pkg::*;
#(
    parameter int W = 20,
    parameter int H = 20,
    localparam int CW   = $clog2(W),
    localparam int RW   = $clog2(H),
    localparam int NPIX = W * H,
    localparam int NW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cont,
    input  logic          in_nempty,
    input  logic          out_nfull,
    input  logic          tail_only,
    output logic          rd,
    output logic          adv,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row,
    output logic          done,
    output logic          idle,
    output logic          ready
);
    conv_state_t state, nstate;
    logic [NW-1:0] cnt;
    logic          last_pix;

    assign last_pix = (cnt == NW'(NPIX - 1));

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start)              nstate = ST_SCAN;
            ST_SCAN:  if (rd && last_pix)     nstate = ST_DRAIN;
            ST_DRAIN: if (adv && tail_only)   nstate = ST_DONE;
            ST_DONE:  if (cont)               nstate = ST_IDLE;
            default:                          nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        rd = 1'b0; adv = 1'b0; done = 1'b0; idle = 1'b0; ready = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_SCAN: begin
                rd    = in_nempty && out_nfull;
                adv   = rd;
                ready = rd && last_pix;
            end
            ST_DRAIN: adv = out_nfull;
            ST_DONE: begin
                done = 1'b1;
                idle = 1'b1;
            end
            default: idle = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) begin
            cnt <= '0;
            col <= '0;
            row <= '0;
        end else if (rd) begin
            cnt <= cnt + 1'b1;
            if (col == CW'(W - 1)) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/conv_stream.sv
module conv_stream
    import conv_pkg::*;
#(
    parameter int W   = 20,
    parameter int H   = 20,
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cont,
    output logic          done,
    output logic          idle,
    output logic          ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_nempty,
    output logic          in_rd,
    output logic [DW-1:0] out_data,
    input  logic          out_nfull,
    output logic          out_wr
);
    localparam int CW = $clog2(W);
    localparam int RW = $clog2(H);

    logic          adv, tail_only, win_vld, res_vld;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic [DW-1:0] win [KN];

    conv_ctrl #(.W(W), .H(H)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cont(cont),
        .in_nempty(in_nempty), .out_nfull(out_nfull), .tail_only(tail_only),
        .rd(in_rd), .adv(adv), .col(col), .row(row),
        .done(done), .idle(idle), .ready(ready)
    );

    conv_window #(.W(W), .H(H), .DW(DW)) u_win (
        .clk(clk), .rst(rst), .adv(adv), .rd(in_rd), .pix(in_data),
        .col(col), .row(row), .win(win), .win_vld(win_vld)
    );

    conv_mac #(.DW(DW), .LAT(LAT)) u_mac (
        .clk(clk), .rst(rst), .adv(adv), .win(win), .vin(win_vld),
        .od(out_data), .ov(res_vld), .tail_only(tail_only)
    );

    assign out_wr = adv && res_vld;
endmodule

// File: rtl/conv_stream_chk.sv
module conv_stream_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic cont,
    input logic done,
    input logic idle,
    input logic ready,
    input logic in_nempty,
    input logic in_rd,
    input logic out_nfull,
    input logic out_wr
);
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        in_rd |-> in_nempty);

    a_r5_no_pop_when_full: assert property (@(posedge clk) disable iff (rst)
        in_rd |-> out_nfull);

    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> out_nfull);

    a_r6_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    a_r7_done_held: assert property (@(posedge clk) disable iff (rst)
        (done && !cont) |=> done);

    a_r7_done_is_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> idle);

    a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        (idle && !done && start) |=> !idle);

    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!in_rd && !out_wr));
endmodule

bind conv_stream conv_stream_chk u_chk (.*);

// File: tb/sim_conv_stream.sv
module sim_conv_stream;
    localparam int CLK_P   = 10;
    localparam int FW      = 20;
    localparam int NPIX    = FW * FW;
    localparam int NOUT    = (FW - 2) * (FW - 2);
    localparam int EXP_LAT = 3;   // R9: LAT+1 with default LAT=2
    localparam int NVEC    = 6;
    // {mode[15:12], stall[11:8], seed[7:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0001, 16'h1117, 16'h122b, 16'h2305, 16'h3409, 16'h103c
    };

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, cont = 1'b0;
    logic        in_nempty = 1'b0, out_nfull = 1'b1;
    logic [31:0] in_data = '0;
    logic        done, idle, ready, in_rd, out_wr;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    int px [NPIX];
    int ex [NOUT];

    always #(CLK_P/2) clk = ~clk;

    conv_stream u0 (
        .clk(clk), .rst(rst), .start(start), .cont(cont),
        .done(done), .idle(idle), .ready(ready),
        .in_data(in_data), .in_nempty(in_nempty), .in_rd(in_rd),
        .out_data(out_data), .out_nfull(out_nfull), .out_wr(out_wr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int pixel(input int mode, input int seed, input int i);
        case (mode)
            0:       return i * seed + 1;
            1:       return (i * 1103515245 + seed * 12345) ^ (i << 7);
            2:       return (i % 2 == 1) ? 32'h7fff_fff0 + i : 32'h8000_0000 + seed;
            default: return seed * 1000;
        endcase
    endfunction

    function automatic bit in_flag(input int stl, input int cyc, input int seed);
        if (stl[0] && ((cyc * 3 + seed) % 7 == 0)) return 1'b0;
        if (stl[2] && ((cyc % 50) < 20)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit out_flag(input int stl, input int cyc, input int seed);
        if (stl[1] && ((cyc * 5 + seed) % 4 == 0)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic build(input int mode, input int seed);
        for (int i = 0; i < NPIX; i++) px[i] = pixel(mode, seed, i);
        for (int r = 2; r < FW; r++) begin
            for (int c = 2; c < FW; c++) begin
                int s = 0;
                for (int dr = 0; dr < 3; dr++)
                    for (int dc = 0; dc < 3; dc++) begin
                        int v = px[(r-2+dr)*FW + (c-2+dc)];
                        if (dr == 1 && dc == 1) s = s + 8 * v;
                        else                    s = s - v;
                    end
                ex[(r-2)*(FW-2) + (c-2)] = s;
            end
        end
    endtask

    task automatic run_frame(input logic [15:0] v, input bit hold_start);
        int mode = int'(v[15:12]);
        int stl  = int'(v[11:8]);
        int seed = int'(v[7:0]);
        int cyc = 0, rdi = 0, wri = 0, rdy = 0, rdybad = 0, v4 = 0, v5 = 0;
        int mism = 0, bad_act = 0, bad_exp = 0, rd42 = -1, first_wr = -1, last_wr = -1;
        int done_cyc = -1, idle1 = 1;
        build(mode, seed);
        while (done_cyc < 0 && cyc < 20000) begin
            @(negedge clk);
            start     = (cyc == 0);
            in_nempty = (cyc == 0) ? 1'b1 : in_flag(stl, cyc, seed);
            out_nfull = (cyc == 0) ? 1'b1 : out_flag(stl, cyc, seed);
            in_data   = (rdi < NPIX) ? px[rdi] : 32'd0;
            #1;
            if (cyc == 1) idle1 = idle;
            if (in_rd && !in_nempty) v4++;
            if (out_wr && !in_nempty && stl != 0 && rdi < NPIX) v4++;
            if ((in_rd || out_wr) && !out_nfull) v5++;
            if (ready) begin
                rdy++;
                if (!(in_rd && rdi == NPIX - 1)) rdybad++;
            end
            if (out_wr) begin
                if (wri < NOUT && out_data != ex[wri] && mism == 0) begin
                    bad_act = out_data; bad_exp = ex[wri];
                end
                if (wri >= NOUT || out_data != ex[wri]) mism++;
                if (wri == 0) first_wr = cyc;
                last_wr = cyc;
                wri++;
            end
            if (in_rd) begin
                if (rdi == 42) rd42 = cyc;
                rdi++;
            end
            if (done) done_cyc = cyc;
            cyc++;
        end
        start = 1'b0;
        chk(idle1 == 0, "R2 idle low after start", idle1, 0);
        chk(rdi == NPIX, "R3 pixels read", rdi, NPIX);
        chk(wri == NOUT, "R3 results written", wri, NOUT);
        chk(mism == 0, (mode == 2) ? "R10 wrapped result" : "R3 result value", bad_act, bad_exp);
        chk(v4 == 0, "R4 strobe while input empty", v4, 0);
        chk(v5 == 0, "R5 strobe while output full", v5, 0);
        chk(rdy == 1 && rdybad == 0, "R6 ready pulse", rdy, 1);
        chk(done_cyc == last_wr + 1, "R7 done after last write", done_cyc, last_wr + 1);
        if (stl == 0) chk(first_wr - rd42 == EXP_LAT, "R9 first result latency", first_wr - rd42, EXP_LAT);
        if (hold_start) begin
            int bad = 0;
            in_nempty = 1'b1; out_nfull = 1'b1;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk); start = 1'b1; #1;
                if (in_rd || !done || !idle) bad++;
            end
            @(negedge clk); start = 1'b0; #1;
            chk(bad == 0 && done, "R8 start ignored in done", bad, 0);
        end
        @(negedge clk); cont = 1'b1; #1;
        chk(done == 1'b1 && idle == 1'b1, "R7 done held until cont", done, 1);
        @(negedge clk); cont = 1'b0; #1;
        chk(done == 1'b0 && idle == 1'b1, "R7 back to idle after cont", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        #1;
        chk(idle && !done && !ready && !in_rd && !out_wr, "R1 reset state", idle, 1);
        @(negedge clk); rst = 1'b0;
        in_nempty = 1'b1; out_nfull = 1'b1;
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            if (in_rd || out_wr || !idle) bad++;
        end
        chk(bad == 0, "R11 no strobes while idle", bad, 0);

        for (int n = 0; n < NVEC; n++) run_frame(VEC[n], n == 1);

        // R1: reset in the middle of a run
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); #1;
        chk(idle && !done && !in_rd && !out_wr && !ready, "R1 reset mid-run", idle, 1);
        rst = 1'b0;
        run_frame(16'h1021, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule